// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit gathers the event flags of a memory-card host controller into four byte-wide status registers and turns them into a single interrupt line. Transfer, command, timeout and CRC events arrive as one-cycle pulses. Each pulse sets a sticky flag. Software clears a flag by writing a one to its bit. Writing back a value it has just read clears only the flags it saw. Writing all ones clears every flag.

The unit also watches three slow pin levels: write protect, the data-line card detect and the dedicated card-detect pin. Each level is synchronised and shown live in status byte 0. A configuration byte picks which detect level counts as the card-present source and whether that level is active high. A change in the chosen presence value sets a change flag, and an insertion also sets an inserted flag. Two mask bytes and a global enable in the configuration byte decide which sticky flags drive the interrupt.

Top module: `cardhost_irq_status`

## Requirements
- R1: After reset, all four status bytes read 0x00 and `irq` is low. This holds while all inputs are low.
- R2: A pulse on `evt_mblk_done` sets status 0 bit 4 and a pulse on `evt_blk_done` sets status 0 bit 5. A pulse on `evt_grp1[k]` sets status 1 bit k. Each flag reads 1 in the cycle after the pulse edge and stays set until it is cleared.
- R3: A write with `wr_sel` = 0 clears each status 0 flag (bits 7..4) whose `wr_data` bit is 1. A write with `wr_sel` = 1 does the same for status 1 bits 7..0. Bits written 0 keep their value, and 0xFF clears every flag.
- R4: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit stays set. Other bits cleared by that write still clear.
- R5: Status 0 bit 1 shows the write-protect level, bit 2 the data-line detect level and bit 3 the detect-pin level. These are raw levels after a two-stage synchroniser, so they are visible two edges after the pin changes. Writes to status 0 do not change them. Status 2 bit 4 shows `cmd_busy`, status 2 bit 5 shows `dat_busy`, and status 3 reads 0x00.
- R6: The configuration byte is written with `wr_sel` = 6. Bit 4 selects active-high detect, bit 5 selects the detect pin as source and bit 6 selects the data line as source; the pin wins when both are set. Bit 7 is the global interrupt enable. Card present is the source level when active high, or its inverse when active low, and it is 0 when no source is selected.
- R7: Status 0 bit 6 is set whenever the selected presence value differs from its value one cycle earlier, including after a change of source or polarity. Status 0 bit 7 is set when presence goes from 0 to 1.
- R8: `wr_sel` = 4 writes mask 0, which enables status 0 bits 7..4. `wr_sel` = 5 writes mask 1, which enables status 1 bits 7..1. Status 1 bit 0 never raises the interrupt. `irq` is the global enable ANDed with any enabled set flag.
- R9: `irq` follows register state in the same cycle. It falls in the cycle after the last enabled flag is cleared, its mask bit is removed, or the global enable is dropped.
- R10: A pin change sets the change flag on the third rising edge after the change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0/1 status clear, 4/5 masks, 6 configuration |
| wr_data | input | 8 | Write data |
| evt_blk_done | input | 1 | Single block done pulse |
| evt_mblk_done | input | 1 | Multi-block done pulse |
| evt_grp1 | input | 8 | Command, timeout, CRC and card-interrupt pulses, one per status 1 bit |
| wp_pin | input | 1 | Raw write-protect level |
| d3_pin | input | 1 | Raw data-line card-detect level |
| cd_pin | input | 1 | Raw card-detect pin level |
| cmd_busy | input | 1 | Command/response busy level |
| dat_busy | input | 1 | Data response busy level |
| sts0 | output | 8 | Status 0: detect and transfer flags plus live levels |
| sts1 | output | 8 | Status 1: command, timeout and CRC flags |
| sts2 | output | 8 | Status 2: live busy levels |
| sts3 | output | 8 | Status 3: reads zero |
| irq | output | 1 | Interrupt output |

## Verification
Two pairs of functions can land on the same clock edge. A flag can be set by its event pulse while software clears it, and the detect logic can set the change flag while a write to status 0 clears other bits. The bench drives an event pulse and a clearing write in one cycle and expects the bit to stay set while the other cleared bits drop. It also moves the detect pin and counts edges to confirm that the change flag appears on the third edge, independent of the live level bits in the same byte.

// File: rtl/chis_pkg.sv
package chis_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ST0  = 3'd0,
        SEL_ST1  = 3'd1,
        SEL_ST2  = 3'd2,
        SEL_ST3  = 3'd3,
        SEL_MSK0 = 3'd4,
        SEL_MSK1 = 3'd5,
        SEL_CFG  = 3'd6
    } reg_sel_e;

    // status 0 bit positions
    localparam int ST0_WP   = 1;
    localparam int ST0_D3   = 2;
    localparam int ST0_PIN  = 3;
    localparam int ST0_LO   = 4;  // first sticky bit of status 0
    localparam int ST2_CMDB = 4;
    localparam int ST2_DATB = 5;

    // indices inside the sticky nibble of status 0
    localparam int N0_MBLK = 0;
    localparam int N0_BLK  = 1;
    localparam int N0_CHG  = 2;
    localparam int N0_INS  = 3;
    localparam int N0_W    = BYTE_W - ST0_LO;

    // synchronised pin indices
    localparam int PIN_WP = 0;
    localparam int PIN_D3 = 1;
    localparam int PIN_CD = 2;
    localparam int N_PINS = 3;

    typedef struct packed {
        logic irq_en;
        logic src_d3;
        logic src_pin;
        logic pol_high;
    } cfg_t;

    function automatic logic card_present(input logic lvl, input logic pol_high);
        return pol_high ? lvl : ~lvl;
    endfunction

    function automatic logic any_enabled(input logic [BYTE_W-1:0] st,
                                         input logic [BYTE_W-1:0] en);
        return |(st & en);
    endfunction
endpackage

// File: rtl/chis_w1c_bank.sv
module chis_w1c_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic flag;
        always_ff @(posedge clk) begin
            if (rst)
                flag <= 1'b0;
            else if (set_vec[i])
                flag <= 1'b1;           // a set in the clearing cycle wins
            else if (clr_en && clr_vec[i])
                flag <= 1'b0;
        end
        assign q[i] = flag;
    end
endmodule

// File: rtl/chis_detect.sv
module chis_detect
    import chis_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NP          = N_PINS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] raw,
    input  logic          pol_high,
    input  logic          src_pin,
    input  logic          src_d3,
    output logic [NP-1:0] lvl,
    output logic          chg_set,
    output logic          ins_set
);
    for (genvar i = 0; i < NP; i++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-2:0], raw[i]};
        end
        assign lvl[i] = chain[SYNC_STAGES-1];
    end

    logic present_now;
    logic present_prev;

    always_comb begin
        if (src_pin)
            present_now = card_present(lvl[PIN_CD], pol_high);
        else if (src_d3)
            present_now = card_present(lvl[PIN_D3], pol_high);
        else
            present_now = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) present_prev <= 1'b0;
        else     present_prev <= present_now;
    end

    assign chg_set = present_now ^ present_prev;
    assign ins_set = present_now & ~present_prev;
endmodule

// File: rtl/chis_ctrl.sv
module chis_ctrl
    import chis_pkg::*;
#(
    parameter int W0 = N0_W,
    parameter int W1 = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask0,
    input  logic              wr_mask1,
    input  logic              wr_cfg,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [W0-1:0]     flags0,
    input  logic [W1-1:0]     flags1,
    output cfg_t              cfg,
    output logic              irq
);
    localparam int CFG_W = $bits(cfg_t);

    logic [W0-1:0] mask0_q;
    logic [W1-1:0] mask1_q;
    cfg_t          cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0_q <= '0;
            mask1_q <= '0;
            cfg_q   <= '0;
        end else begin
            if (wr_mask0) mask0_q <= wr_data[BYTE_W-1 -: W0];
            if (wr_mask1) mask1_q <= wr_data[BYTE_W-1 -: W1];
            if (wr_cfg)   cfg_q   <= cfg_t'(wr_data[BYTE_W-1 -: CFG_W]);
        end
    end

    logic pend0, pend1;
    always_comb begin
        pend0 = any_enabled({{(BYTE_W-W0){1'b0}}, flags0}, {{(BYTE_W-W0){1'b0}}, mask0_q});
        pend1 = any_enabled({{(BYTE_W-W1){1'b0}}, flags1}, {{(BYTE_W-W1){1'b0}}, mask1_q});
    end

    assign cfg = cfg_q;
    assign irq = cfg_q.irq_en & (pend0 | pend1);
endmodule

// File: rtl/cardhost_irq_status.sv
module cardhost_irq_status
    import chis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              evt_blk_done,
    input  logic              evt_mblk_done,
    input  logic [BYTE_W-1:0] evt_grp1,
    input  logic              wp_pin,
    input  logic              d3_pin,
    input  logic              cd_pin,
    input  logic              cmd_busy,
    input  logic              dat_busy,
    output logic [BYTE_W-1:0] sts0,
    output logic [BYTE_W-1:0] sts1,
    output logic [BYTE_W-1:0] sts2,
    output logic [BYTE_W-1:0] sts3,
    output logic              irq
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    logic [N_PINS-1:0] raw, lvl;
    logic              chg_set, ins_set;
    cfg_t              cfg;

    always_comb begin
        raw         = '0;
        raw[PIN_WP] = wp_pin;
        raw[PIN_D3] = d3_pin;
        raw[PIN_CD] = cd_pin;
    end

    chis_detect #(.SYNC_STAGES(SYNC_STAGES), .NP(N_PINS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw),
        .pol_high (cfg.pol_high),
        .src_pin  (cfg.src_pin),
        .src_d3   (cfg.src_d3),
        .lvl      (lvl),
        .chg_set  (chg_set),
        .ins_set  (ins_set)
    );

    logic [N0_W-1:0] set0, flags0;
    always_comb begin
        set0          = '0;
        set0[N0_MBLK] = evt_mblk_done;
        set0[N0_BLK]  = evt_blk_done;
        set0[N0_CHG]  = chg_set;
        set0[N0_INS]  = ins_set;
    end

    chis_w1c_bank #(.W(N0_W)) u_bank0 (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set0),
        .clr_en  (wr_en && sel == SEL_ST0),
        .clr_vec (wr_data[BYTE_W-1:ST0_LO]),
        .q       (flags0)
    );

    logic [BYTE_W-1:0] flags1;
    chis_w1c_bank #(.W(BYTE_W)) u_bank1 (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_grp1),
        .clr_en  (wr_en && sel == SEL_ST1),
        .clr_vec (wr_data),
        .q       (flags1)
    );

    chis_ctrl #(.W0(N0_W), .W1(BYTE_W-1)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_mask0 (wr_en && sel == SEL_MSK0),
        .wr_mask1 (wr_en && sel == SEL_MSK1),
        .wr_cfg   (wr_en && sel == SEL_CFG),
        .wr_data  (wr_data),
        .flags0   (flags0),
        .flags1   (flags1[BYTE_W-1:1]),
        .cfg      (cfg),
        .irq      (irq)
    );

    always_comb begin
        sts0                     = '0;
        sts0[BYTE_W-1:ST0_LO]    = flags0;
        sts0[ST0_WP]             = lvl[PIN_WP];
        sts0[ST0_D3]             = lvl[PIN_D3];
        sts0[ST0_PIN]            = lvl[PIN_CD];
        sts2                     = '0;
        sts2[ST2_CMDB]           = cmd_busy;
        sts2[ST2_DATB]           = dat_busy;
    end

    assign sts1 = flags1;
    assign sts3 = '0;
endmodule

// File: rtl/chis_checker.sv
module chis_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       evt_blk_done,
    input logic       evt_mblk_done,
    input logic [7:0] evt_grp1,
    input logic [7:0] sts0,
    input logic [7:0] sts1,
    input logic       irq
);
    assert_mblk_set_R2: assert property (@(posedge clk) disable iff (rst)
        evt_mblk_done |=> sts0[4]);

    assert_grp1_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_grp1) |=> ((sts1 & $past(evt_grp1)) == $past(evt_grp1)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd1 && ((wr_data & evt_grp1) == 8'h00))
        |=> ((sts1 & $past(wr_data)) == 8'h00));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && evt_grp1 == 8'h00) |=> $stable(sts1));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_blk_done && wr_en && wr_sel == 3'd0 && wr_data[5]) |=> sts0[5]);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (sts0[7:4] == 4'h0 && sts1[7:1] == 7'h00) |-> !irq);
endmodule

bind cardhost_irq_status chis_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .evt_blk_done  (evt_blk_done),
    .evt_mblk_done (evt_mblk_done),
    .evt_grp1      (evt_grp1),
    .sts0          (sts0),
    .sts1          (sts1),
    .irq           (irq)
);

// File: tb/cardhost_irq_status_bench.sv
`timescale 1ns/1ps
module cardhost_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_sel;
    logic [7:0] wr_data;
    logic       evt_blk_done, evt_mblk_done;
    logic [7:0] evt_grp1;
    logic       wp_pin, d3_pin, cd_pin, cmd_busy, dat_busy;
    logic [7:0] sts0, sts1, sts2, sts3;
    logic       irq;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    cardhost_irq_status u_cardhost_irq_status (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_blk_done(evt_blk_done), .evt_mblk_done(evt_mblk_done), .evt_grp1(evt_grp1),
        .wp_pin(wp_pin), .d3_pin(d3_pin), .cd_pin(cd_pin),
        .cmd_busy(cmd_busy), .dat_busy(dat_busy),
        .sts0(sts0), .sts1(sts1), .sts2(sts2), .sts3(sts3), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse1(input logic [7:0] v);
        evt_grp1 = v;
        @(negedge clk);
        evt_grp1 = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "sts0", sts0, 8'h00);
        chk("R1", "sts1", sts1, 8'h00);
        chk("R1", "sts2", sts2, 8'h00);
        chk("R1", "sts3", sts3, 8'h00);
        chk("R1", "irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_events;
        logic [7:0] acc = 8'h00;
        for (int k = 0; k < 8; k++) begin
            pulse1(8'h01 << k);
            acc |= (8'h01 << k);
            chk("R2", "sts1 accumulate", sts1, acc);
        end
        evt_mblk_done = 1'b1; @(negedge clk); evt_mblk_done = 1'b0;
        chk("R2", "sts0 mblk", sts0 & 8'hF0, 8'h10);
        evt_blk_done = 1'b1; @(negedge clk); evt_blk_done = 1'b0;
        chk("R2", "sts0 blk", sts0 & 8'hF0, 8'h30);
        idle(3);
        chk("R2", "sts0 holds", sts0 & 8'hF0, 8'h30);
    endtask

    task automatic t_w1c;
        wr(3'd1, 8'h0F);
        chk("R3", "partial clear", sts1, 8'hF0);
        wr(3'd1, 8'h00);
        chk("R3", "zero write keeps", sts1, 8'hF0);
        wr(3'd1, 8'hFF);
        chk("R3", "full clear sts1", sts1, 8'h00);
        wr(3'd0, 8'h10);
        chk("R3", "clear mblk only", sts0 & 8'hF0, 8'h20);
        wr(3'd0, 8'hFF);
        chk("R3", "full clear sts0", sts0 & 8'hF0, 8'h00);
    endtask

    task automatic t_race;
        pulse1(8'h08);
        // bit 2 set and cleared together, bit 3 cleared alone
        evt_grp1 = 8'h04; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h0C;
        @(negedge clk);
        evt_grp1 = 8'h00; wr_en = 1'b0; wr_data = 8'h00;
        chk("R4", "set wins over clear", sts1, 8'h04);
        evt_blk_done = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'hFF;
        @(negedge clk);
        evt_blk_done = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        chk("R4", "blk set wins", sts0 & 8'hF0, 8'h20);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        chk("R4", "cleared after", sts1, 8'h00);
    endtask

    task automatic t_live;
        wp_pin = 1'b1;
        @(negedge clk);
        chk("R5", "wp after one edge", sts0 & 8'h02, 8'h00);
        @(negedge clk);
        chk("R5", "wp after two edges", sts0 & 8'h02, 8'h02);
        wr(3'd0, 8'hFF);
        chk("R5", "wp unaffected by write", sts0 & 8'h02, 8'h02);
        wp_pin = 1'b0;
        idle(2);
        chk("R5", "wp low again", sts0 & 8'h02, 8'h00);
        cmd_busy = 1'b1; #1;
        chk("R5", "cmd busy", sts2, 8'h10);
        dat_busy = 1'b1; cmd_busy = 1'b0; #1;
        chk("R5", "dat busy", sts2, 8'h20);
        dat_busy = 1'b0;
        chk("R5", "sts3 zero", sts3, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_irq;
        wr(3'd5, 8'h02);
        pulse1(8'h02);
        chk("R8", "flag set", sts1, 8'h02);
        chk("R8", "no irq without enable", {7'b0, irq}, 8'h00);
        wr(3'd6, 8'h80);
        chk("R8", "irq with enable", {7'b0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        chk("R9", "irq drops on unmask", {7'b0, irq}, 8'h00);
        wr(3'd5, 8'hFF);
        chk("R8", "irq back on mask", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'hFF);
        chk("R9", "irq drops on clear", {7'b0, irq}, 8'h00);
        pulse1(8'h01);
        chk("R8", "card interrupt flag", sts1, 8'h01);
        chk("R8", "bit0 never interrupts", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h20);
        evt_blk_done = 1'b1; @(negedge clk); evt_blk_done = 1'b0;
        chk("R8", "mask0 blk irq", {7'b0, irq}, 8'h01);
        wr(3'd6, 8'h00);
        chk("R9", "irq drops on global disable", {7'b0, irq}, 8'h00);
        wr(3'd6, 8'h80);
        chk("R8", "irq returns", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h20);
        chk("R9", "irq drops on sts0 clear", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_detect;
        // pin source, active low, pin low -> present
        wr(3'd6, 8'h20);
        @(negedge clk);
        chk("R7", "select source insert", sts0 & 8'hC0, 8'hC0);
        wr(3'd0, 8'hC0);
        cd_pin = 1'b1;
        idle(2);
        chk("R10", "no change at second edge", sts0 & 8'hC0, 8'h00);
        chk("R5", "pin level live", sts0 & 8'h08, 8'h08);
        @(negedge clk);
        chk("R10", "removal change at third edge", sts0 & 8'hC0, 8'h40);
        wr(3'd0, 8'hC0);
        cd_pin = 1'b0;
        idle(3);
        chk("R7", "reinsertion", sts0 & 8'hC0, 8'hC0);
        wr(3'd0, 8'hC0);
        // data-line source, active high, level low -> absent
        wr(3'd6, 8'h50);
        @(negedge clk);
        chk("R6", "d3 active high absent", sts0 & 8'hC0, 8'h40);
        wr(3'd0, 8'hC0);
        d3_pin = 1'b1;
        idle(3);
        chk("R6", "d3 insert", sts0 & 8'hC0, 8'hC0);
        chk("R5", "d3 level live", sts0 & 8'h04, 8'h04);
        wr(3'd0, 8'hC0);
        // both sources: pin wins, pin low active high -> absent
        wr(3'd6, 8'h70);
        @(negedge clk);
        chk("R6", "pin has priority", sts0 & 8'hC0, 8'h40);
        wr(3'd0, 8'hC0);
        idle(2);
        chk("R7", "stable no change", sts0 & 8'hC0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'h00;
        evt_blk_done = 1'b0; evt_mblk_done = 1'b0; evt_grp1 = 8'h00;
        wp_pin = 1'b0; d3_pin = 1'b0; cd_pin = 1'b0; cmd_busy = 1'b0; dat_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_events;
        t_w1c;
        t_race;
        t_live;
        t_irq;
        t_detect;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule